// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a clocked front end for an external asynchronous static RAM holding 131,072 bytes. A requester hands it one access at a time over a valid/ready port: a 17-bit address, a byte of write data and a flag that selects write or read. The controller turns each request into a fixed sequence of clock-counted phases on the memory pins. The pins are a low-active select, a high-active select, a low-active write strobe, a low-active output enable, the address bus, and a data bus split into an outgoing byte, its driver enable and an incoming byte. A pad ring joins the split data bus into the tristate pins.

Every nanosecond limit of the memory is a parameter counted in clock cycles and rounded up for the clock in use. These limits are the read access time, the write strobe width, the hold after the strobe and the bus turnaround after a read. The defaults fit a 10 ns clock and a 20 ns memory. A read returns its byte together with a single-cycle response pulse. A write returns nothing. The controller takes no new request until the current phase sequence has finished.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is held, and in every idle cycle, the low-active select is 1, the high-active select is 0, the write strobe is 1, the output enable is 1, the data driver enable is 0 and ready is 1. The response pulse is 0.
- R2: A request is taken on a clock edge where valid and ready are both 1. Ready then stays 0 for the busy cycles of the sequence: RD_CYC cycles for a read, and TURN_CYC (if applied) plus WR_PULSE_CYC plus WR_HOLD_CYC cycles for a write. Ready returns to 1 on the cycle after.
- R3: A read drives both selects active, output enable 0, write strobe 1 and driver enable 0 for exactly RD_CYC cycles, starting in the cycle after acceptance. The address pins carry the requested address throughout.
- R4: The incoming byte is registered at the end of the last read cycle. The response pulse is 1 for exactly one cycle, RD_CYC cycles after the acceptance edge, with the byte stored at that address on the data output.
- R5: A write holds the write strobe at 0 for exactly WR_PULSE_CYC cycles, with both selects active, output enable 1, driver enable 1 and the request's byte and address on the pins.
- R6: The data driver enable is never 1 in a cycle where the output enable is 0.
- R7: After the strobe returns to 1, the selects stay active and the address, data and driver enable stay unchanged for WR_HOLD_CYC cycles.
- R8: A write that follows a read is preceded by TURN_CYC cycles in which both selects are inactive, output enable is 1 and driver enable is 0.
- R9: A write that follows a write, or is the first access after reset, starts its strobe in the cycle after acceptance.
- R10: Valid raised while ready is 0 is not taken, and changes nothing on the memory pins.
- R11: The whole 17-bit range is reachable; addresses 0 and 131,071 appear unchanged on the address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte returned by a read |
| mem_sel_n | output | 1 | Low-active chip select |
| mem_sel | output | 1 | High-active chip select |
| mem_wr_n | output | 1 | Low-active write strobe |
| mem_rd_n | output | 1 | Low-active output enable |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_drv | output | 1 | Driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte read from the memory pins |

## Verification
All pins are registered, so every phase of an access shows up starting in the cycle after the acceptance edge. The response pulse and its byte follow RD_CYC cycles after that edge. A write strobe falls one cycle after acceptance, or TURN_CYC cycles later when a read came before it. At each acceptance the bench expands the request into one expected pin record per cycle and pops one record per clock. It compares every output at the falling edge, halfway through the cycle, when all registers from the preceding rising edge have settled. Requests presented while the controller is busy go through the same comparison, so any pin they disturb shows up as a miscompare.

// File: rtl/sram_port_pkg.sv
// Shared types for the SRAM controller: the access phases and the pin
// control bundle derived from each phase. Assumes single-chip, single-word use.
package sram_port_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic sel;     // both chip selects active
        logic rd_n;    // output enable, low active
        logic wr_n;    // write strobe, low active
        logic dq_drv;  // controller drives the data bus
    } pin_ctl_t;

    // Pin levels that belong to each phase
    function automatic pin_ctl_t pins_for(phase_t ph);
        pin_ctl_t p;
        p.sel    = (ph == PH_READ) || (ph == PH_STROBE) || (ph == PH_HOLD);
        p.rd_n   = (ph != PH_READ);
        p.wr_n   = (ph != PH_STROBE);
        p.dq_drv = (ph == PH_STROBE) || (ph == PH_HOLD);
        return p;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_seq.sv
// Phase sequencer: steps each accepted request through read, turnaround,
// strobe and hold phases, each lasting a parameter number of cycles (all >= 1).
// Pin controls are registered from the next phase so the memory sees no glitches.
module sram_phase_seq
    import sram_port_pkg::*;
#(
    parameter int RD_CYC       = 2,
    parameter int WR_PULSE_CYC = 2,
    parameter int WR_HOLD_CYC  = 1,
    parameter int TURN_CYC     = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  logic     acc_write,
    output logic     ready,
    output logic     capture,
    output pin_ctl_t ctl
);
    localparam int MAX_CYC = max4(RD_CYC, WR_PULSE_CYC, WR_HOLD_CYC, TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    phase_t           phase, phase_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             last_rd, last_rd_nx;

    // Next phase, phase length and read-history decision
    always_comb begin
        phase_nx   = phase;
        cnt_nx     = cnt;
        last_rd_nx = last_rd;
        capture    = 1'b0;
        unique case (phase)
            PH_IDLE: if (accept) begin
                if (!acc_write) begin
                    phase_nx = PH_READ;
                    cnt_nx   = CNT_W'(RD_CYC - 1);
                end else if (last_rd) begin
                    phase_nx = PH_TURN;
                    cnt_nx   = CNT_W'(TURN_CYC - 1);
                end else begin
                    phase_nx   = PH_STROBE;
                    cnt_nx     = CNT_W'(WR_PULSE_CYC - 1);
                    last_rd_nx = 1'b0;
                end
            end
            PH_READ: if (cnt == '0) begin
                phase_nx   = PH_IDLE;
                capture    = 1'b1;
                last_rd_nx = 1'b1;
            end else cnt_nx = cnt - 1'b1;
            PH_TURN: if (cnt == '0) begin
                phase_nx   = PH_STROBE;
                cnt_nx     = CNT_W'(WR_PULSE_CYC - 1);
                last_rd_nx = 1'b0;
            end else cnt_nx = cnt - 1'b1;
            PH_STROBE: if (cnt == '0) begin
                phase_nx = PH_HOLD;
                cnt_nx   = CNT_W'(WR_HOLD_CYC - 1);
            end else cnt_nx = cnt - 1'b1;
            PH_HOLD: if (cnt == '0) phase_nx = PH_IDLE;
                     else cnt_nx = cnt - 1'b1;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase state, counter and registered pin controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            last_rd <= 1'b0;
            ctl     <= pins_for(PH_IDLE);
        end else begin
            phase   <= phase_nx;
            cnt     <= cnt_nx;
            last_rd <= last_rd_nx;
            ctl     <= pins_for(phase_nx);
        end
    end

    assign ready = (phase == PH_IDLE);

    // Checker: strobe low-time counter
    logic [CNT_W:0] wr_low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_low_cnt <= '0;
        else if (!ctl.wr_n) wr_low_cnt <= wr_low_cnt + 1'b1;
        else                wr_low_cnt <= '0;
    end

    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.wr_n) |-> (wr_low_cnt == (CNT_W+1)'(WR_PULSE_CYC)));

    assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.wr_n |-> (ctl.sel && ctl.rd_n));

endmodule

// File: rtl/sram_data_path.sv
// Data path: holds the accepted address and write byte on the memory pins
// until the next acceptance, and registers read data with a response pulse.
// Assumes mem_dq_in is settled by the last cycle of the read phase.
module sram_data_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Latch address and write byte on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= acc_addr;
            dq_out   <= acc_wdata;
        end
    end

    // Capture read byte and raise a one-cycle response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= dq_in;
        end
    end

    assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_port_ctrl.sv
// Top of the asynchronous SRAM controller. One request at a time over a
// valid/ready port; all memory pins come from registers. Timing parameters
// are cycle counts rounded up from the memory's ns limits (defaults: 10 ns clock).
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int RD_CYC       = 2,
    parameter int WR_PULSE_CYC = 2,
    parameter int WR_HOLD_CYC  = 1,
    parameter int TURN_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drv,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic     accept;
    logic     capture;
    pin_ctl_t ctl;

    assign accept = req_valid && req_ready;

    sram_phase_seq #(
        .RD_CYC      (RD_CYC),
        .WR_PULSE_CYC(WR_PULSE_CYC),
        .WR_HOLD_CYC (WR_HOLD_CYC),
        .TURN_CYC    (TURN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_write(req_write),
        .ready    (req_ready),
        .capture  (capture),
        .ctl      (ctl)
    );

    sram_data_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_addr (req_addr),
        .acc_wdata(req_wdata),
        .capture  (capture),
        .dq_in    (mem_dq_in),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_out),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign mem_sel_n  = !ctl.sel;
    assign mem_sel    = ctl.sel;
    assign mem_wr_n   = ctl.wr_n;
    assign mem_rd_n   = ctl.rd_n;
    assign mem_dq_drv = ctl.dq_drv;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_drv && !rsp_valid));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    assert_read_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_sel_n && mem_sel && mem_wr_n));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drv |-> mem_rd_n);

    assert_pins_stable_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (mem_dq_drv && mem_sel));

endmodule

// File: tb/tb_sram_port_ctrl.sv
// Bench: behavioural memory plus a per-cycle expected-pin queue model.
// Requirements covered: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11.
module tb_sram_port_ctrl;
    localparam int RD_CYC = 2, WR_PULSE_CYC = 2, WR_HOLD_CYC = 1, TURN_CYC = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [7:0] rsp_rdata;
    logic mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_drv;
    logic [16:0] mem_addr;
    logic [7:0] mem_dq_out;
    logic [7:0] mem_dq_in = 8'hEE;

    always #2 clk = ~clk;   // 250 MHz

    sram_port_ctrl #(.RD_CYC(RD_CYC), .WR_PULSE_CYC(WR_PULSE_CYC),
                     .WR_HOLD_CYC(WR_HOLD_CYC), .TURN_CYC(TURN_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_drv(mem_dq_drv),
        .mem_dq_in(mem_dq_in));

    // Behavioural asynchronous memory, evaluated mid-cycle
    logic [7:0] chip [int];
    always @(negedge clk) begin
        if (!mem_sel_n && mem_sel && !mem_wr_n) chip[int'(mem_addr)] = mem_dq_out;
        if (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n)
            mem_dq_in <= chip.exists(int'(mem_addr)) ? chip[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in <= 8'hEE;
    end

    // Expected per-cycle record
    typedef struct packed {
        logic busy, sel, rd_n, wr_n, drv, chk_addr, chk_data, rsp;
        logic [16:0] addr;
        logic [7:0] data, rdata;
        logic [3:0] tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    logic [7:0] ref_mem [int];
    bit m_ready = 1'b1, last_rd = 1'b0, seen_edge = 1'b0, poke = 1'b0, done = 1'b0;
    int vectors = 0, fails = 0;

    function automatic exp_t idle_rec();
        exp_t e = '0;
        e.rd_n = 1'b1; e.wr_n = 1'b1; e.tag = 4'd1;   // R1 idle levels
        return e;
    endfunction

    function automatic exp_t pin_rec(logic s, logic r, logic w, logic d, logic ca, logic cd,
                                     logic [16:0] a, logic [7:0] dt, logic [3:0] t);
        exp_t e = '0;
        e.busy = 1'b1; e.sel = s; e.rd_n = r; e.wr_n = w; e.drv = d;
        e.chk_addr = ca; e.chk_data = cd; e.addr = a; e.data = dt; e.tag = t;
        return e;
    endfunction

    // Reference model: expand accepted requests into expected cycles
    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (!rst_n) begin
            q.delete();
            cur = idle_rec();
            last_rd = 1'b0;
            m_ready = 1'b1;
        end else begin
            if (req_valid && m_ready) begin
                if (!req_write) begin
                    exp_t r;
                    for (int i = 0; i < RD_CYC; i++)    // R3 read phase
                        q.push_back(pin_rec(1, 0, 1, 0, 1, 0, req_addr, '0, 4'd3));
                    r = idle_rec();
                    r.rsp = 1'b1; r.tag = 4'd4;          // R4 response
                    r.rdata = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                    q.push_back(r);
                    last_rd = 1'b1;
                end else begin
                    if (last_rd)
                        for (int i = 0; i < TURN_CYC; i++)   // R8 turnaround
                            q.push_back(pin_rec(0, 1, 1, 0, 0, 0, '0, '0, 4'd8));
                    for (int i = 0; i < WR_PULSE_CYC; i++)   // R5 / R9 strobe
                        q.push_back(pin_rec(1, 1, 0, 1, 1, 1, req_addr, req_wdata,
                                            last_rd ? 4'd5 : 4'd9));
                    for (int i = 0; i < WR_HOLD_CYC; i++)    // R7 hold
                        q.push_back(pin_rec(1, 1, 1, 1, 1, 1, req_addr, req_wdata, 4'd7));
                    ref_mem[int'(req_addr)] = req_wdata;
                    last_rd = 1'b0;
                end
            end
            cur = (q.size() != 0) ? q.pop_front() : idle_rec();
            m_ready = !cur.busy && (q.size() == 0);
        end
    end

    task automatic fail_line(int tag, string what, longint act, longint expv);
        fails++;
        $display("FAIL R%0d %s actual=%0h expected=%0h t=%0t", tag, what, act, expv, $time);
    endtask

    // Compare every output mid-cycle
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            int t;
            t = poke ? 10 : int'(cur.tag);   // R10 disturbances reported under R10
            vectors++;
            if (mem_sel_n !== !cur.sel) fail_line(t, "sel_n", mem_sel_n, !cur.sel);
            if (mem_sel   !== cur.sel)  fail_line(t, "sel", mem_sel, cur.sel);
            if (mem_rd_n  !== cur.rd_n) fail_line(t, "rd_n", mem_rd_n, cur.rd_n);
            if (mem_wr_n  !== cur.wr_n) fail_line(t, "wr_n", mem_wr_n, cur.wr_n);
            if (mem_dq_drv !== cur.drv) fail_line(t, "dq_drv", mem_dq_drv, cur.drv);
            if (mem_dq_drv && !mem_rd_n) fail_line(6, "drive during read", 1, 0);  // R6
            if (req_ready !== m_ready) fail_line(poke ? 10 : 2, "ready", req_ready, m_ready);  // R2
            if (rsp_valid !== cur.rsp) fail_line(4, "rsp_valid", rsp_valid, cur.rsp);
            if (cur.rsp && rsp_rdata !== cur.rdata) fail_line(4, "rsp_rdata", rsp_rdata, cur.rdata);
            if (cur.chk_addr && mem_addr !== cur.addr)   // R3 R11 address pins
                fail_line(poke ? 10 : 11, "addr", mem_addr, cur.addr);
            if (cur.chk_data && mem_dq_out !== cur.data)
                fail_line(t, "dq_out", mem_dq_out, cur.data);
        end
    end

    task automatic do_req(input logic wr, input logic [16:0] a, input logic [7:0] d,
                          input bit with_poke);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);                      // accepted at the edge just passed
        if (with_poke) begin                 // R10: request while busy
            poke = 1'b1;
            req_addr = ~a; req_write = !wr; req_wdata = ~d;
            @(negedge clk);
            poke = 1'b0;
        end
        req_valid = 1'b0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (5) @(negedge clk);           // R1 reset levels compared each cycle
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_req(1'b0, 17'h00000, 8'h00, 0);   // read of untouched location
        do_req(1'b1, 17'h00000, 8'hA5, 0);   // R8 turnaround after read
        do_req(1'b0, 17'h00000, 8'h00, 0);
        do_req(1'b1, 17'h1FFFF, 8'h3C, 0);   // R11 top address
        do_req(1'b1, 17'h00001, 8'h77, 0);   // R9 write after write
        do_req(1'b0, 17'h1FFFF, 8'h00, 0);
        do_req(1'b0, 17'h00001, 8'h00, 0);
        do_req(1'b1, 17'h00005, 8'h5A, 1);   // R10 poke during write
        do_req(1'b0, 17'h00005, 8'h00, 1);   // R10 poke during read
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            logic [16:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = (lfsr[3:1] == 3'd7) ? 17'h1FFFF : {14'd0, lfsr[3:1]};
            do_req(lfsr[0], a, lfsr[15:8], 0);
        end
        repeat (6) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end
endmodule